// File: doc/BRIEF.md
# Coin-Operated Toll Lane Controller

This block runs one toll lane. A car sensor reports whether a vehicle is in the lane, and a 2-bit coin sensor reports at most one deposited coin per clock cycle. While a car waits, the controller accumulates its payment in 5-cent steps. Each credit level is a separate named state.

When the credit reaches the 35-cent toll, the light turns from red to green. The car may then leave, and the lane returns to idle. If the car leaves before the toll is covered, the controller latches an alarm. The alarm stays raised until an operator pulses the alarm-clear input.

Reset is synchronous and active high. All outputs are decoded from the registered state, so they change one clock edge after the inputs that cause the change.

States, in encoding order:
- `ST_IDLE`: no car in the lane.
- `ST_C0`, `ST_C5`, `ST_C10`, `ST_C15`, `ST_C20`, `ST_C25`, `ST_C30`: car present with the named credit in cents.
- `ST_PAID`: toll covered.
- `ST_EVADE`: car left unpaid.

Transitions:
- `ST_IDLE` goes to `ST_C0` when a car is present.
- A credit state goes to a higher credit state, or to `ST_PAID`, on a coin.
- Any credit state goes to `ST_EVADE` when the car is gone.
- `ST_PAID` goes to `ST_IDLE` when the car is gone.
- `ST_EVADE` goes to `ST_IDLE` on alarm clear.
- Every other case holds the current state.

Top module: `toll_lane_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller enters `ST_IDLE`, so that red=1, green=0 and alarm=0 after that edge.
- R2: In `ST_IDLE`, the controller stays idle while `car_present`=0 and moves to `ST_C0` when `car_present`=1. A coin seen while idle adds no credit to the next car.
- R3: Coin codes are 2'b00 no coin, 2'b01 = 5 cents, 2'b10 = 10 cents and 2'b11 = 25 cents. In a credit state with `car_present`=1, the coin value is added to the credit held.
- R4: A coin that brings the credit to 35 cents or more moves the controller to `ST_PAID`, and any excess is discarded. Below 35 cents, the light stays red.
- R5: In `ST_IDLE` and in every credit state, the outputs are red=1, green=0 and alarm=0.
- R6: In `ST_PAID`, the outputs are red=0, green=1 and alarm=0. The controller stays in `ST_PAID` while `car_present`=1 and ignores coins there.
- R7: In `ST_PAID`, `car_present`=0 returns the controller to `ST_IDLE`.
- R8: In a credit state, `car_present`=0 moves the controller to `ST_EVADE`, even when a coin is reported in the same cycle. There the outputs are red=1, green=0 and alarm=1.
- R9: `ST_EVADE` holds, regardless of car and coin inputs, until `alarm_clear`=1. It then returns to `ST_IDLE`.
- R10: `alarm_clear` has no effect in any state other than `ST_EVADE`.
- R11: Exactly one of red and green is lit at all times, and alarm is never raised with green.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| car_present | input | 1 | 1 while a car occupies the lane |
| coin_code | input | 2 | Coin reported this cycle (see R3) |
| alarm_clear | input | 1 | Operator acknowledge of an unpaid departure |
| red_light | output | 1 | Stop light |
| green_light | output | 1 | Go light |
| alarm | output | 1 | Unpaid departure alarm |

## Verification
The bench targets the exact toll boundary. Seven nickels must turn the light green on the seventh coin, not the sixth, and 30 cents plus a quarter must also reach `ST_PAID`; an off-by-one threshold or an overflowing credit sum would leave the light red or wrap to a low credit.

It also drives:
- a coin in the same cycle as the car leaving, which a controller giving coins priority would wrongly accept instead of alarming;
- coins deposited while idle, which a leaky design would credit to the next car;
- alarm clears outside the alarm state, which should do nothing.

Long random runs with sticky car presence then compare every cycle against a bench model of the state machine.

// File: rtl/toll_pkg.sv
package toll_pkg;

    // Credit is counted in 5-cent steps.
    localparam int STEP_W       = 3;
    localparam int TOLL_STEPS   = 7;   // 35 cents
    localparam int NICKEL_STEPS = 1;
    localparam int DIME_STEPS   = 2;
    localparam int QUART_STEPS  = 5;
    localparam int SUM_W        = STEP_W + 1;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_C0    = 4'd1,
        ST_C5    = 4'd2,
        ST_C10   = 4'd3,
        ST_C15   = 4'd4,
        ST_C20   = 4'd5,
        ST_C25   = 4'd6,
        ST_C30   = 4'd7,
        ST_PAID  = 4'd8,
        ST_EVADE = 4'd9
    } lane_state_t;

    typedef enum logic [1:0] {
        COIN_NONE    = 2'b00,
        COIN_NICKEL  = 2'b01,
        COIN_DIME    = 2'b10,
        COIN_QUARTER = 2'b11
    } coin_t;

endpackage

// File: rtl/toll_coin_decode.sv
module toll_coin_decode
    import toll_pkg::*;
(
    input  logic [1:0]        coin_code,
    output logic [STEP_W-1:0] coin_steps
);
    always_comb begin
        unique case (coin_t'(coin_code))
            COIN_NONE:    coin_steps = '0;
            COIN_NICKEL:  coin_steps = STEP_W'(NICKEL_STEPS);
            COIN_DIME:    coin_steps = STEP_W'(DIME_STEPS);
            COIN_QUARTER: coin_steps = STEP_W'(QUART_STEPS);
        endcase
    end
endmodule

// File: rtl/toll_next_state.sv
module toll_next_state
    import toll_pkg::*;
(
    input  lane_state_t       cur_state,
    input  logic              car_present,
    input  logic [STEP_W-1:0] coin_steps,
    input  logic              alarm_clear,
    output lane_state_t       nxt_state
);
    logic [SUM_W-1:0] credit_sum;

    // Credit held in the current state, plus the coin seen this cycle.
    assign credit_sum = SUM_W'(cur_state - ST_C0) + SUM_W'(coin_steps);

    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            ST_IDLE: begin
                if (car_present) nxt_state = ST_C0;
            end
            ST_C0, ST_C5, ST_C10, ST_C15, ST_C20, ST_C25, ST_C30: begin
                if (!car_present)
                    nxt_state = ST_EVADE;
                else if (credit_sum >= SUM_W'(TOLL_STEPS))
                    nxt_state = ST_PAID;
                else
                    nxt_state = lane_state_t'(4'(credit_sum) + 4'(ST_C0));
            end
            ST_PAID: begin
                if (!car_present) nxt_state = ST_IDLE;
            end
            ST_EVADE: begin
                if (alarm_clear) nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/toll_light_decode.sv
module toll_light_decode
    import toll_pkg::*;
(
    input  lane_state_t cur_state,
    output logic        red_light,
    output logic        green_light,
    output logic        alarm
);
    always_comb begin
        red_light   = 1'b1;
        green_light = 1'b0;
        alarm       = 1'b0;
        unique case (cur_state)
            ST_PAID: begin
                red_light   = 1'b0;
                green_light = 1'b1;
            end
            ST_EVADE: alarm = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/toll_lane_ctrl.sv
module toll_lane_ctrl
    import toll_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       car_present,
    input  logic [1:0] coin_code,
    input  logic       alarm_clear,
    output logic       red_light,
    output logic       green_light,
    output logic       alarm
);
    lane_state_t       state_q;
    lane_state_t       state_d;
    logic [STEP_W-1:0] coin_steps;

    toll_coin_decode u_coin (
        .coin_code  (coin_code),
        .coin_steps (coin_steps)
    );

    toll_next_state u_next (
        .cur_state   (state_q),
        .car_present (car_present),
        .coin_steps  (coin_steps),
        .alarm_clear (alarm_clear),
        .nxt_state   (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    toll_light_decode u_lights (
        .cur_state   (state_q),
        .red_light   (red_light),
        .green_light (green_light),
        .alarm       (alarm)
    );
endmodule

// File: rtl/toll_lane_chk.sv
module toll_lane_chk (
    input logic clk,
    input logic rst,
    input logic car_present,
    input logic alarm_clear,
    input logic red_light,
    input logic green_light,
    input logic alarm
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (red_light && !green_light && !alarm));

    // R11
    one_light_chk: assert property (@(posedge clk) disable iff (rst)
        (red_light ^ green_light) && !(alarm && green_light));

    // R4
    green_needs_car_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(green_light) |-> $past(car_present));

    // R6
    paid_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (green_light && car_present) |=> green_light);

    // R7
    paid_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (green_light && !car_present) |=> (red_light && !alarm));

    // R8
    alarm_on_leave_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm) |-> !$past(car_present));

    // R9
    alarm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm && !alarm_clear) |=> alarm);

    // R9
    alarm_release_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm && alarm_clear) |=> (!alarm && red_light));
endmodule

bind toll_lane_ctrl toll_lane_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .car_present (car_present),
    .alarm_clear (alarm_clear),
    .red_light   (red_light),
    .green_light (green_light),
    .alarm       (alarm)
);

// File: tb/tb_toll_lane_ctrl.sv
module tb_toll_lane_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       car_present = 1'b0;
    logic [1:0] coin_code = 2'b00;
    logic       alarm_clear = 1'b0;
    logic       red_light, green_light, alarm;

    int n_checks = 0;
    int n_fails  = 0;

    // Bench model: 0 idle, 1 collecting, 2 paid, 3 alarm.
    int m_mode   = 0;
    int m_credit = 0;

    always #10 clk = ~clk;

    toll_lane_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .car_present (car_present),
        .coin_code   (coin_code),
        .alarm_clear (alarm_clear),
        .red_light   (red_light),
        .green_light (green_light),
        .alarm       (alarm)
    );

    function automatic int coin_cents(input logic [1:0] code);
        case (code)
            2'b01:   return 5;
            2'b10:   return 10;
            2'b11:   return 25;
            default: return 0;
        endcase
    endfunction

    function automatic logic [2:0] exp_lights(input int mode);
        case (mode)
            2:       return 3'b010;
            3:       return 3'b101;
            default: return 3'b100;
        endcase
    endfunction

    task automatic model_step(input logic c, input logic [1:0] k, input logic clr);
        case (m_mode)
            0: if (c) begin m_mode = 1; m_credit = 0; end
            1: if (!c) m_mode = 3;
               else begin
                   m_credit += coin_cents(k);
                   if (m_credit >= 35) m_mode = 2;
               end
            2: if (!c) m_mode = 0;
            default: if (clr) m_mode = 0;
        endcase
    endtask

    task automatic check(input string tag);
        logic [2:0] got, want;
        got  = {red_light, green_light, alarm};
        want = exp_lights(m_mode);
        n_checks++;
        if (got !== want) begin
            n_fails++;
            $display("FAIL %s: {red,green,alarm} got %b expected %b (t=%0t)", tag, got, want, $time);
        end
    endtask

    // Drive at negedge, let one posedge update, sample at the next negedge.
    task automatic step(input logic c, input logic [1:0] k, input logic clr, input string tag);
        car_present = c;
        coin_code   = k;
        alarm_clear = clr;
        @(posedge clk);
        model_step(c, k, clr);
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        car_present = 1'b0;
        coin_code = 2'b00;
        alarm_clear = 1'b0;
        @(posedge clk);
        @(negedge clk);
        m_mode = 0;
        m_credit = 0;
        check("R1 reset");
        rst = 1'b0;
    endtask

    initial begin
        #4_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic c;
        @(negedge clk);
        do_reset();

        // R2: coins while idle add nothing to the next car.
        step(1'b0, 2'b11, 1'b0, "R2 idle coin");
        step(1'b0, 2'b10, 1'b0, "R2 idle coin");
        step(1'b1, 2'b11, 1'b0, "R2 arrive, coin ignored");
        step(1'b1, 2'b11, 1'b0, "R3 quarter");
        step(1'b1, 2'b01, 1'b0, "R4 30 cents still red");
        step(1'b1, 2'b00, 1'b0, "R5 partial red");
        step(1'b1, 2'b01, 1'b0, "R4 35 reaches paid");
        step(1'b1, 2'b11, 1'b0, "R6 coin in paid ignored");
        step(1'b1, 2'b00, 1'b1, "R10 clear in paid ignored");
        step(1'b0, 2'b00, 1'b0, "R7 leave after paid");

        // R3/R4: seven nickels, green only on the seventh.
        step(1'b1, 2'b00, 1'b0, "R2 arrive");
        for (int i = 0; i < 7; i++)
            step(1'b1, 2'b01, (i == 3), (i == 3) ? "R10 clear while collecting" : "R3 nickel");
        step(1'b0, 2'b00, 1'b0, "R7 leave");

        // R4: excess discarded, quarter+quarter.
        step(1'b1, 2'b00, 1'b0, "R2 arrive");
        step(1'b1, 2'b11, 1'b0, "R3 quarter");
        step(1'b1, 2'b11, 1'b0, "R4 overshoot to paid");
        step(1'b0, 2'b00, 1'b0, "R7 leave");

        // R8: coin in the same cycle as leaving still alarms.
        step(1'b1, 2'b00, 1'b0, "R2 arrive");
        step(1'b1, 2'b10, 1'b0, "R3 dime");
        step(1'b0, 2'b11, 1'b0, "R8 leave with coin");
        step(1'b1, 2'b11, 1'b0, "R9 alarm holds");
        step(1'b0, 2'b01, 1'b0, "R9 alarm holds");
        step(1'b1, 2'b00, 1'b1, "R9 clear releases");
        step(1'b1, 2'b00, 1'b0, "R2 arrive after clear");
        step(1'b0, 2'b00, 1'b0, "R8 leave at zero credit");
        step(1'b0, 2'b00, 1'b1, "R9 clear");

        // Random, sticky car presence.
        c = 1'b0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 9) == 0) c = ~c;
            step(c, 2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0), "R11 random");
        end

        do_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule